// File: doc/BRIEF.md
# Serial Audio Link Tag and Command Slot Checker

This block sits behind a frame deserializer on a serial audio and modem link. Each frame begins with a 16-bit tag slot. Twelve 20-bit slots follow it. The deserializer hands over one slot word at a time, together with the slot number. The checker accepts a tag slot only when it is the first slot after a frame-start pulse. From the tag it takes the ready flag, the codec number and a 12-bit mask that says which later slots carry data. For the rest of that frame, the mask gates every later slot.

The block decodes three kinds of slot:
- the command/status address slot (slot 1);
- the command/status data slot (slot 2);
- the audio slots (slots 3 to 12).

Each accepted slot produces a one-cycle strobe with its decoded fields. An audio slot yields its upper 16 bits as a sample. The input `dir_out` selects how a slot is checked: outbound (controller to codec) or inbound. Reserved-bit errors, odd-address errors and data-tail errors are kept in three sticky flags until the host pulses a clear.

The control is a three-state machine:
- `ST_IDLE`: no frame is open. Every slot is dropped. A frame-start pulse moves it to `ST_WAIT_TAG`.
- `ST_WAIT_TAG`: the mask has been cleared and the tag is awaited. A frame-start pulse stays in `ST_WAIT_TAG`. Slot 0 moves it to `ST_BODY`. Any other slot is dropped.
- `ST_BODY`: slots 1 to 12 are gated by the mask. A frame-start pulse moves it to `ST_WAIT_TAG`. Slot 12, whether it is accepted or not, moves it to `ST_IDLE`.

A second slot 0 seen in `ST_BODY` is dropped.

Top module: `slot_chk`

## Requirements
- R1: A tag slot (`slot_idx` 0) accepted in `ST_WAIT_TAG` gives a one-cycle `tag_stb` one clock later. It also reports the tag fields, taken from the low 16 bits of `slot_word`: `tag_ready` = bit 15, `tag_mask` = bits 14:3, `tag_codec` = bits 1:0. After reset every output is 0.
- R2: Slot k (1..12) is accepted only when `tag_mask` bit 12-k of the current frame is 1. So bit 11 gates slot 1 and bit 0 gates slot 12. A slot that is not accepted produces no strobe.
- R3: The mask is cleared on each frame-start pulse. A slot strobe is dropped in any of these cases:
  - it arrives in the same cycle as a frame-start pulse;
  - it arrives before the tag of the frame;
  - it arrives before any frame start at all.
- R4: An accepted address slot gives `addr_stb` with `addr_reg` = bits 18:12. When outbound, `addr_rd` = bit 19 (1 = read) and `addr_req` = 0. When inbound, `addr_rd` = 0 and `addr_req` = bits 11:2.
- R5: An accepted address slot whose `addr_reg` bit 0 is 1 sets `err_odd`.
- R6: `err_rsv` is set by any of these:
  - tag bit 2 nonzero;
  - address bits 1:0 nonzero;
  - address bits 11:2 nonzero when outbound;
  - address bit 19 set when inbound.
- R7: An accepted data slot gives `data_stb` with `data_reg` = bits 19:4. Nonzero bits 3:0 set `err_data`.
- R8: An accepted slot 3..12 gives `smp_stb` with `smp_data` = bits 19:4 and `smp_slot` = the slot number.
- R9: Each error flag stays set until an `err_clr` pulse clears it. A new error in the same cycle as the clear wins.
- R10: Each output strobe lasts one cycle and follows its input slot strobe by exactly one clock. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_out | input | 1 | 1 = outbound slots, 0 = inbound slots |
| frame_start | input | 1 | Pulse marking the start of a frame |
| slot_stb | input | 1 | Slot word present |
| slot_idx | input | 4 | Slot number 0..12 |
| slot_word | input | 20 | Slot bits, MSB first; tag in bits 15:0 |
| err_clr | input | 1 | Clears the sticky error flags |
| tag_stb | output | 1 | Tag decoded |
| tag_ready | output | 1 | Ready flag of the tag |
| tag_codec | output | 2 | Codec number of the tag |
| tag_mask | output | 12 | Slot-valid mask; bit 11 = slot 1 |
| addr_stb | output | 1 | Address slot decoded |
| addr_rd | output | 1 | Read request (outbound only) |
| addr_reg | output | 7 | Register address |
| addr_req | output | 10 | Data-request bits (inbound only) |
| data_stb | output | 1 | Data slot decoded |
| data_reg | output | 16 | Register data |
| smp_stb | output | 1 | Audio sample valid |
| smp_slot | output | 4 | Slot number of the sample |
| smp_data | output | 16 | Upper 16 bits of the audio slot |
| err_rsv | output | 1 | Sticky reserved-bit error |
| err_odd | output | 1 | Sticky odd-address error |
| err_data | output | 1 | Sticky data-tail error |

## Verification
The table-driven frames vary the direction, the tag mask and the field contents. Outbound and inbound frames that carry the same kind of address slot are compared, which separates the read-flag path from the request-bit path. One frame enables slot 3 and another masks it off, which shows whether the gating is taken from the mask. A frame with an odd address and nonzero reserved and tail bits lights all three error classes, while a clean inbound frame with a set leading bit lights only the reserved class; together they show that each class is set by its own cause. Directed frames cover the other cases:
- slots that arrive before a tag, before any frame, or in the cycle of a frame start;
- a mask that is not carried into the next frame;
- slot 12 at the edge of the mask;
- error flags that stay set until cleared.

// File: rtl/slot_chk_pkg.sv
package slot_chk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_TAG,
        ST_BODY
    } phase_t;

    localparam int ERR_RSV  = 2;
    localparam int ERR_ODD  = 1;
    localparam int ERR_DATA = 0;
endpackage

// File: rtl/slot_chk_decode.sv
module slot_chk_decode #(
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16,
    parameter int NV     = 12,
    parameter int CID_W  = 2,
    parameter int ADDR_W = 7,
    parameter int REQ_W  = 10,
    parameter int SMP_W  = 16
) (
    input  logic [SLOT_W-1:0] word,
    input  logic              dir_out,
    output logic              t_ready,
    output logic [NV-1:0]     t_mask,
    output logic [CID_W-1:0]  t_codec,
    output logic              t_rsv,
    output logic              a_rd,
    output logic [ADDR_W-1:0] a_addr,
    output logic [REQ_W-1:0]  a_req,
    output logic              a_rsv,
    output logic              a_odd,
    output logic [SMP_W-1:0]  d_val,
    output logic              d_rsv
);
    localparam int TAIL_W  = SLOT_W - 1 - ADDR_W - REQ_W;
    localparam int DTAIL_W = SLOT_W - SMP_W;
    localparam int RSV_POS = TAG_W - 2 - NV;

    logic [TAG_W-1:0]   tag;
    logic               lead;
    logic [REQ_W-1:0]   mid;
    logic [TAIL_W-1:0]  tail;
    logic [DTAIL_W-1:0] dtail;

    always_comb begin
        tag     = word[TAG_W-1:0];
        t_ready = tag[TAG_W-1];
        t_mask  = tag[TAG_W-2 -: NV];
        t_rsv   = tag[RSV_POS];
        t_codec = tag[CID_W-1:0];

        lead    = word[SLOT_W-1];
        a_addr  = word[SLOT_W-2 -: ADDR_W];
        mid     = word[SLOT_W-2-ADDR_W -: REQ_W];
        tail    = word[TAIL_W-1:0];
        a_rd    = dir_out ? lead : 1'b0;
        a_req   = dir_out ? '0 : mid;
        a_rsv   = (dir_out ? (|mid) : lead) | (|tail);
        a_odd   = a_addr[0];

        d_val   = word[SLOT_W-1 -: SMP_W];
        dtail   = word[DTAIL_W-1:0];
        d_rsv   = |dtail;
    end
endmodule

// File: rtl/slot_chk_fsm.sv
module slot_chk_fsm
    import slot_chk_pkg::*;
#(
    parameter int NV    = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             slot_stb,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic [NV-1:0]    mask_in,
    output logic             tag_take,
    output logic             body_take,
    output logic [NV-1:0]    mask_q
);
    localparam int NSLOT = 2 ** IDX_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NV);

    phase_t state, nxt;
    logic [NSLOT-1:0] slot_on;
    logic             live;

    assign slot_on[0] = 1'b0;
    for (genvar k = 1; k < NSLOT; k++) begin : g_on
        if (k <= NV) begin : g_used
            assign slot_on[k] = mask_q[NV-k];
        end else begin : g_pad
            assign slot_on[k] = 1'b0;
        end
    end

    assign live      = slot_stb && !frame_start;
    assign tag_take  = live && (state == ST_WAIT_TAG) && (slot_idx == '0);
    assign body_take = live && (state == ST_BODY) && slot_on[slot_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (frame_start) nxt = ST_WAIT_TAG;
            ST_WAIT_TAG: if (frame_start) nxt = ST_WAIT_TAG;
                         else if (tag_take) nxt = ST_BODY;
            ST_BODY:     if (frame_start) nxt = ST_WAIT_TAG;
                         else if (slot_stb && slot_idx == LAST) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask_q <= '0;
        else if (frame_start) mask_q <= '0;
        else if (tag_take)    mask_q <= mask_in;
    end

    // R3: a frame start leaves no mask from the previous frame
    a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mask_q == '0));
    // R2: a body slot is never slot 0
    a_r2_body_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        body_take |-> (slot_idx != '0));
endmodule

// File: rtl/slot_chk_errs.sv
module slot_chk_errs #(
    parameter int N_ERR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [N_ERR-1:0] set,
    output logic [N_ERR-1:0] flag
);
    for (genvar e = 0; e < N_ERR; e++) begin : g_err
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag[e] <= 1'b0;
            else if (set[e]) flag[e] <= 1'b1;
            else if (clr)    flag[e] <= 1'b0;
        end

        // R9: a flag stays set unless cleared
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[e] && !clr) |=> flag[e]);
    end
endmodule

// File: rtl/slot_chk.sv
module slot_chk
    import slot_chk_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int TAG_W  = 16,
    parameter int NV     = 12,
    parameter int CID_W  = 2,
    parameter int ADDR_W = 7,
    parameter int REQ_W  = 10,
    parameter int SMP_W  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic              frame_start,
    input  logic              slot_stb,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [SLOT_W-1:0] slot_word,
    input  logic              err_clr,
    output logic              tag_stb,
    output logic              tag_ready,
    output logic [CID_W-1:0]  tag_codec,
    output logic [NV-1:0]     tag_mask,
    output logic              addr_stb,
    output logic              addr_rd,
    output logic [ADDR_W-1:0] addr_reg,
    output logic [REQ_W-1:0]  addr_req,
    output logic              data_stb,
    output logic [SMP_W-1:0]  data_reg,
    output logic              smp_stb,
    output logic [IDX_W-1:0]  smp_slot,
    output logic [SMP_W-1:0]  smp_data,
    output logic              err_rsv,
    output logic              err_odd,
    output logic              err_data
);
    localparam int N_ERR = 3;
    localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(2);

    logic              t_ready, t_rsv, a_rd, a_rsv, a_odd, d_rsv;
    logic [NV-1:0]     t_mask, mask_q;
    logic [CID_W-1:0]  t_codec;
    logic [ADDR_W-1:0] a_addr;
    logic [REQ_W-1:0]  a_req;
    logic [SMP_W-1:0]  d_val;
    logic              tag_take, body_take, addr_take, data_take, smp_take;
    logic [N_ERR-1:0]  err_set, err_q;

    slot_chk_decode #(
        .SLOT_W(SLOT_W), .TAG_W(TAG_W), .NV(NV), .CID_W(CID_W),
        .ADDR_W(ADDR_W), .REQ_W(REQ_W), .SMP_W(SMP_W)
    ) u_dec (
        .word(slot_word), .dir_out(dir_out),
        .t_ready(t_ready), .t_mask(t_mask), .t_codec(t_codec), .t_rsv(t_rsv),
        .a_rd(a_rd), .a_addr(a_addr), .a_req(a_req), .a_rsv(a_rsv), .a_odd(a_odd),
        .d_val(d_val), .d_rsv(d_rsv)
    );

    slot_chk_fsm #(.NV(NV), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .slot_stb(slot_stb), .slot_idx(slot_idx), .mask_in(t_mask),
        .tag_take(tag_take), .body_take(body_take), .mask_q(mask_q)
    );

    assign addr_take = body_take && (slot_idx == IDX_ADDR);
    assign data_take = body_take && (slot_idx == IDX_DATA);
    assign smp_take  = body_take && (slot_idx > IDX_DATA);

    always_comb begin
        err_set           = '0;
        err_set[ERR_RSV]  = (tag_take && t_rsv) || (addr_take && a_rsv);
        err_set[ERR_ODD]  = addr_take && a_odd;
        err_set[ERR_DATA] = data_take && d_rsv;
    end

    slot_chk_errs #(.N_ERR(N_ERR)) u_err (
        .clk(clk), .rst_n(rst_n), .clr(err_clr), .set(err_set), .flag(err_q)
    );

    assign err_rsv  = err_q[ERR_RSV];
    assign err_odd  = err_q[ERR_ODD];
    assign err_data = err_q[ERR_DATA];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_stb <= 1'b0; tag_ready <= 1'b0; tag_codec <= '0; tag_mask <= '0;
            addr_stb <= 1'b0; addr_rd <= 1'b0; addr_reg <= '0; addr_req <= '0;
            data_stb <= 1'b0; data_reg <= '0;
            smp_stb <= 1'b0; smp_slot <= '0; smp_data <= '0;
        end else begin
            tag_stb  <= tag_take;
            addr_stb <= addr_take;
            data_stb <= data_take;
            smp_stb  <= smp_take;
            if (tag_take) begin
                tag_ready <= t_ready;
                tag_codec <= t_codec;
                tag_mask  <= t_mask;
            end
            if (addr_take) begin
                addr_rd  <= a_rd;
                addr_reg <= a_addr;
                addr_req <= a_req;
            end
            if (data_take) data_reg <= d_val;
            if (smp_take) begin
                smp_slot <= slot_idx;
                smp_data <= d_val;
            end
        end
    end

    // R10: at most one strobe per cycle
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tag_stb, addr_stb, data_stb, smp_stb}));
    // R3: nothing leaves in the cycle after a frame start
    a_r3_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !(tag_stb || addr_stb || data_stb || smp_stb));
    // R8: samples only come from audio slots
    a_r8_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> (smp_slot > IDX_DATA && smp_slot <= IDX_W'(NV)));
    // R4: a read flag only appears for outbound slots
    a_r4_rd_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && $rose(addr_rd)) |-> $past(dir_out));
endmodule

// File: tb/slot_chk_tb.sv
module slot_chk_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        dir;
        logic [15:0] tag;
        logic [19:0] w1;
        logic [19:0] w2;
        logic [19:0] w3;
        logic        e_ready;
        logic [1:0]  e_codec;
        logic        e_as;
        logic        e_rd;
        logic [6:0]  e_addr;
        logic [9:0]  e_req;
        logic        e_ds;
        logic [15:0] e_data;
        logic        e_ss;
        logic [15:0] e_smp;
        logic [2:0]  e_err;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{1'b1, 16'hF000, 20'hA6000, 20'h12340, 20'hABCDE,
          1'b1, 2'd0, 1'b1, 1'b1, 7'h26, 10'h000, 1'b1, 16'h1234, 1'b1, 16'hABCD, 3'b000},
        '{1'b0, 16'hE002, 20'h02FFC, 20'hBEEF0, 20'h11111,
          1'b1, 2'd2, 1'b1, 1'b0, 7'h02, 10'h3FF, 1'b1, 16'hBEEF, 1'b0, 16'h0000, 3'b000},
        '{1'b1, 16'hF000, 20'h05004, 20'h5555A, 20'h00010,
          1'b1, 2'd0, 1'b1, 1'b0, 7'h05, 10'h000, 1'b1, 16'h5555, 1'b1, 16'h0001, 3'b111},
        '{1'b0, 16'hE002, 20'h90000, 20'h00000, 20'h22222,
          1'b1, 2'd2, 1'b1, 1'b0, 7'h10, 10'h000, 1'b1, 16'h0000, 1'b0, 16'h0000, 3'b100},
        '{1'b1, 16'h0004, 20'hA6000, 20'h12340, 20'hABCDE,
          1'b0, 2'd0, 1'b0, 1'b0, 7'h00, 10'h000, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'b100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_out = 1'b0;
    logic        frame_start = 1'b0;
    logic        slot_stb = 1'b0;
    logic [3:0]  slot_idx = '0;
    logic [19:0] slot_word = '0;
    logic        err_clr = 1'b0;
    logic        tag_stb, tag_ready, addr_stb, addr_rd, data_stb, smp_stb;
    logic [1:0]  tag_codec;
    logic [11:0] tag_mask;
    logic [6:0]  addr_reg;
    logic [9:0]  addr_req;
    logic [15:0] data_reg, smp_data;
    logic [3:0]  smp_slot;
    logic        err_rsv, err_odd, err_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_chk u_dut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .frame_start(frame_start),
        .slot_stb(slot_stb), .slot_idx(slot_idx), .slot_word(slot_word),
        .err_clr(err_clr), .tag_stb(tag_stb), .tag_ready(tag_ready),
        .tag_codec(tag_codec), .tag_mask(tag_mask), .addr_stb(addr_stb),
        .addr_rd(addr_rd), .addr_reg(addr_reg), .addr_req(addr_req),
        .data_stb(data_stb), .data_reg(data_reg), .smp_stb(smp_stb),
        .smp_slot(smp_slot), .smp_data(smp_data), .err_rsv(err_rsv),
        .err_odd(err_odd), .err_data(err_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send(input logic [3:0] idx, input logic [19:0] w);
        @(negedge clk);
        slot_stb  = 1'b1;
        slot_idx  = idx;
        slot_word = w;
        @(negedge clk);
        slot_stb  = 1'b0;
    endtask

    task automatic clear_errs();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs",
            {tag_stb, tag_ready, tag_codec, tag_mask, addr_stb, data_stb, smp_stb},
            '0);
        chk("R9 reset errors", {err_rsv, err_odd, err_data}, 3'b000);

        // R3: slot before any frame start is dropped
        dir_out = 1'b1;
        send(4'd1, 20'hA6000);
        chk("R3 slot before frame", addr_stb, 1'b0);

        for (int i = 0; i < 5; i++) begin
            vec_t v;
            v = VECS[i];
            clear_errs();
            dir_out = v.dir;
            start_frame();
            send(4'd0, {4'h0, v.tag});
            chk("R1 tag strobe", tag_stb, 1'b1);
            chk("R1 tag ready", tag_ready, v.e_ready);
            chk("R1 tag codec", tag_codec, v.e_codec);
            chk("R1 tag mask", tag_mask, v.tag[14:3]);
            send(4'd1, v.w1);
            chk("R2 addr strobe", addr_stb, v.e_as);
            if (v.e_as) begin
                chk("R4 read flag", addr_rd, v.e_rd);
                chk("R4 address", addr_reg, v.e_addr);
                chk("R4 request bits", addr_req, v.e_req);
            end
            send(4'd2, v.w2);
            chk("R7 data strobe", data_stb, v.e_ds);
            if (v.e_ds) chk("R7 data value", data_reg, v.e_data);
            send(4'd3, v.w3);
            chk("R2 sample strobe", smp_stb, v.e_ss);
            if (v.e_ss) begin
                chk("R8 sample value", smp_data, v.e_smp);
                chk("R8 sample slot", smp_slot, 4'd3);
            end
            chk("R5 R6 R7 error flags", {err_rsv, err_odd, err_data}, v.e_err);
        end

        // R3: slot before the tag is dropped; R2/R8 slot 12 edge
        clear_errs();
        dir_out = 1'b1;
        start_frame();
        send(4'd3, 20'h12345);
        chk("R3 slot before tag", smp_stb, 1'b0);
        send(4'd0, 20'h00008);
        chk("R1 mask slot 12 only", tag_mask, 12'h001);
        send(4'd11, 20'h77777);
        chk("R2 slot 11 masked", smp_stb, 1'b0);
        send(4'd12, 20'hFEDC9);
        chk("R8 slot 12 sample", smp_data, 16'hFEDC);
        chk("R8 slot 12 number", smp_slot, 4'd12);
        @(negedge clk);
        chk("R10 single cycle pulse", smp_stb, 1'b0);

        // R3: mask not carried into the next frame
        start_frame();
        send(4'd12, 20'hFEDC9);
        chk("R3 mask cleared", smp_stb, 1'b0);

        // R3: tag in the same cycle as frame start is dropped
        @(negedge clk);
        frame_start = 1'b1;
        slot_stb = 1'b1;
        slot_idx = 4'd0;
        slot_word = 20'h0F000;
        @(negedge clk);
        frame_start = 1'b0;
        slot_stb = 1'b0;
        chk("R3 slot with frame start", tag_stb, 1'b0);

        // R9: sticky until cleared
        send(4'd0, 20'h00004);
        chk("R9 error set", err_rsv, 1'b1);
        start_frame();
        send(4'd0, 20'h0F000);
        chk("R9 error held", err_rsv, 1'b1);
        clear_errs();
        chk("R9 error cleared", err_rsv, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule